// File: doc/BRIEF.md
# Strobed Configuration Port with Routing Table

This block is the receiving end of a narrow configuration port. The host drives an 8-bit word. Bit 7 is a strobe, and bits 6:0 carry a code. The host first drives the code with the strobe low, then raises the strobe. Each low-to-high transition of the strobe hands over one code. The port is asynchronous to the block clock, so the strobe and the code pass through a two-flop synchroniser, and the rising edge is detected after it.

A code with bit 6 set chooses one of 64 six-bit registers. A code with bit 6 clear is a six-bit value, and it is stored into the register chosen last. The chosen register can be read back at any time on a 7-bit output.

Registers 0 to 3 build one routing entry:

| Register | Holds |
|---|---|
| 0 | Upper half of the destination index |
| 1 | Lower half of the destination index |
| 2 | Upper half of the source index |
| 3 | Lower half of the source index |

Storing a value into register 3 commits the entry into a routing table. The table maps every destination to exactly one source. One source may feed many destinations. The audio path reads the table through a combinational lookup port.

Top module: `cfgp_router`

## Requirements
- R1: After reset all 64 registers hold 0, the chosen register is 0, every routing entry holds source 0, and `rd_data` is 0.
- R2: Only a low-to-high transition of `cfg_port[7]` acts. The effect is visible by the third rising clock edge after the strobe is first sampled high. Holding the strobe high, or changing the code while it is high, changes nothing.
- R3: A code with bit 6 = 1 chooses register `code[5:0]`. No register contents change.
- R4: A code with bit 6 = 0 stores `code[5:0]` into the chosen register. The choice is kept, so successive values go to the same register.
- R5: `rd_data` equals `{1'b0, chosen register}`.
- R6: Storing value v into register 3 commits a routing entry. The destination is `{reg0, reg1}` (12 bits, reg0 in the upper half). The source is `{reg2, v}`. Register 3 also keeps v.
- R7: A later commit to the same destination replaces its source. Commits to other destinations may carry the same source, and earlier entries are untouched.
- R8: A commit whose destination is at or beyond `ROUTE_DEPTH` (default 16) leaves the whole table unchanged. Destination `ROUTE_DEPTH-1` is accepted.
- R9: `lookup_src` combinationally shows the entry for `lookup_dst`. It shows 0 when `lookup_dst` is at or beyond `ROUTE_DEPTH`.
- R10: Storing a value into any register other than 3, and choosing any register, never changes the routing table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_port | input | 8 | Bit 7 strobe, bits 6:0 code (asynchronous) |
| rd_data | output | 7 | Read-back of the chosen register, upper bit 0 |
| lookup_dst | input | 12 | Destination index to look up |
| lookup_src | output | 12 | Source routed to `lookup_dst` |

## Verification
Two things can happen in the same clock edge: a store into register 3, and a routing commit that reads the other three registers and the new value. At that same edge, the lookup port may be looking at the destination being committed. The bench provokes both by parking `lookup_dst` on the destination before the final strobe. A behavioural model then checks `lookup_src` and `rd_data` on every clock, so a stale or early table update shows up as a mismatch in that exact cycle. Strobes held only two cycles low and high are also mixed with random codes, to press consecutive events against each other.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int HALF_W_DEF = 6;
  localparam int SYNC_DEF   = 2;
  localparam int COMMIT_REG = 3;

  // bit above the value field marks a register choice
  function automatic logic code_is_select(input logic [HALF_W_DEF:0] code);
    return code[HALF_W_DEF];
  endfunction

  // upper half first, then lower half
  function automatic logic [2*HALF_W_DEF-1:0] join_halves(
      input logic [HALF_W_DEF-1:0] hi, input logic [HALF_W_DEF-1:0] lo);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/cfgp_strobe_sync.sv
module cfgp_strobe_sync #(
  parameter int CODE_W = 7,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_raw,
  input  logic [CODE_W-1:0] code_raw,
  output logic              ev_valid,
  output logic [CODE_W-1:0] ev_code
);
  logic [STAGES:0] stb_pipe;
  logic [STAGES-1:0][CODE_W-1:0] code_pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_pipe  <= '0;
      code_pipe <= '0;
    end else begin
      stb_pipe  <= {stb_pipe[STAGES-1:0], strobe_raw};
      code_pipe <= {code_pipe[STAGES-2:0], code_raw};
    end
  end

  assign ev_valid = stb_pipe[STAGES-1] & ~stb_pipe[STAGES];
  assign ev_code  = code_pipe[STAGES-1];

  // R2
  strobe_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |=> !ev_valid);
endmodule

// File: rtl/cfgp_regfile.sv
module cfgp_regfile
  import cfgp_pkg::*;
#(
  parameter int HALF_W = HALF_W_DEF,
  parameter int NREG   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [HALF_W:0]   ev_code,
  output logic [HALF_W:0]   rd_val,
  output logic              wr_pulse,
  output logic [$clog2(NREG)-1:0] wr_idx,
  output logic [HALF_W-1:0] wr_val,
  output logic [HALF_W-1:0] reg0_val,
  output logic [HALF_W-1:0] reg1_val,
  output logic [HALF_W-1:0] reg2_val
);
  localparam int SEL_W = $clog2(NREG);

  logic [NREG-1:0][HALF_W-1:0] regs_q;
  logic [SEL_W-1:0] sel_q;
  logic sel_pulse;

  assign sel_pulse = ev_valid &&  code_is_select(ev_code);
  assign wr_pulse  = ev_valid && !code_is_select(ev_code);
  assign wr_idx    = sel_q;
  assign wr_val    = ev_code[HALF_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sel_q <= '0;
    else if (sel_pulse) sel_q <= ev_code[SEL_W-1:0];
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 regs_q[g] <= '0;
      else if (wr_pulse && sel_q == SEL_W'(g))    regs_q[g] <= wr_val;
    end
  end

  assign rd_val   = {1'b0, regs_q[sel_q]};
  assign reg0_val = regs_q[0];
  assign reg1_val = regs_q[1];
  assign reg2_val = regs_q[2];

  // R3
  select_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_pulse |=> sel_q == $past(ev_code[SEL_W-1:0]));
  // R4
  value_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> (regs_q[$past(sel_q)] == $past(wr_val)) && $stable(sel_q));
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_valid |=> $stable(regs_q) && $stable(sel_q));
endmodule

// File: rtl/cfgp_route_table.sv
module cfgp_route_table
  import cfgp_pkg::*;
#(
  parameter int HALF_W = HALF_W_DEF,
  parameter int DEPTH  = 16,
  parameter int SEL_W  = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_pulse,
  input  logic [SEL_W-1:0]    wr_idx,
  input  logic [HALF_W-1:0]   wr_val,
  input  logic [HALF_W-1:0]   dst_hi,
  input  logic [HALF_W-1:0]   dst_lo,
  input  logic [HALF_W-1:0]   src_hi,
  input  logic [2*HALF_W-1:0] lookup_dst,
  output logic [2*HALF_W-1:0] lookup_src
);
  localparam int IDX_W = 2 * HALF_W;
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0][IDX_W-1:0] tab_q;
  logic [IDX_W-1:0] dst_idx, src_idx;
  logic commit, commit_hit, commit_miss;

  assign commit      = wr_pulse && (wr_idx == SEL_W'(COMMIT_REG));
  assign dst_idx     = join_halves(dst_hi, dst_lo);
  assign src_idx     = join_halves(src_hi, wr_val);
  assign commit_hit  = commit && (32'(dst_idx) < 32'(DEPTH));
  assign commit_miss = commit && !(32'(dst_idx) < 32'(DEPTH));

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    tab_q[g] <= '0;
      else if (commit_hit && dst_idx == IDX_W'(g))   tab_q[g] <= src_idx;
    end
  end

  always_comb begin
    if (32'(lookup_dst) < 32'(DEPTH)) lookup_src = tab_q[lookup_dst[AW-1:0]];
    else                              lookup_src = '0;
  end

  // R6
  commit_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_hit |=> tab_q[$past(dst_idx[AW-1:0])] == $past(src_idx));
  // R8
  far_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_miss |=> $stable(tab_q));
  // R10
  no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(tab_q));
endmodule

// File: rtl/cfgp_router.sv
module cfgp_router
  import cfgp_pkg::*;
#(
  parameter int HALF_W      = HALF_W_DEF,
  parameter int ROUTE_DEPTH = 16,
  parameter int SYNC_STAGES = SYNC_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [HALF_W+1:0]   cfg_port,
  output logic [HALF_W:0]     rd_data,
  input  logic [2*HALF_W-1:0] lookup_dst,
  output logic [2*HALF_W-1:0] lookup_src
);
  localparam int NREG  = 2 ** HALF_W;
  localparam int SEL_W = $clog2(NREG);

  logic              ev_valid;
  logic [HALF_W:0]   ev_code;
  logic              wr_pulse;
  logic [SEL_W-1:0]  wr_idx;
  logic [HALF_W-1:0] wr_val, r0, r1, r2;

  cfgp_strobe_sync #(.CODE_W(HALF_W+1), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .strobe_raw(cfg_port[HALF_W+1]), .code_raw(cfg_port[HALF_W:0]),
    .ev_valid(ev_valid), .ev_code(ev_code));

  cfgp_regfile #(.HALF_W(HALF_W), .NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_code(ev_code),
    .rd_val(rd_data), .wr_pulse(wr_pulse), .wr_idx(wr_idx), .wr_val(wr_val),
    .reg0_val(r0), .reg1_val(r1), .reg2_val(r2));

  cfgp_route_table #(.HALF_W(HALF_W), .DEPTH(ROUTE_DEPTH), .SEL_W(SEL_W)) u_tab (
    .clk(clk), .rst_n(rst_n), .wr_pulse(wr_pulse), .wr_idx(wr_idx),
    .wr_val(wr_val), .dst_hi(r0), .dst_lo(r1), .src_hi(r2),
    .lookup_dst(lookup_dst), .lookup_src(lookup_src));

  // R5
  rd_top_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[HALF_W] == 1'b0);
endmodule

// File: tb/sim_cfgp_router.sv
module sim_cfgp_router;
  localparam int DEPTH = 16;

  logic clk = 0, rst_n = 0;
  logic [7:0]  cfg_port = 8'h00;
  logic [11:0] lookup_dst = 12'd0;
  logic [6:0]  rd_data;
  logic [11:0] lookup_src;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  int mreg[64];
  int msel;
  int mtab[DEPTH];
  logic [7:0] hist[$];

  always #5 clk = ~clk;

  cfgp_router #(.ROUTE_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_port(cfg_port), .rd_data(rd_data),
    .lookup_dst(lookup_dst), .lookup_src(lookup_src));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // model: a strobe low->high seen in port samples two and three edges back
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (mreg[i]) mreg[i] = 0;
      foreach (mtab[i]) mtab[i] = 0;
      msel = 0;
      hist = '{8'h00, 8'h00, 8'h00};
    end else begin
      if (hist[1][7] && !hist[2][7]) begin
        if (hist[1][6]) msel = int'(hist[1][5:0]);
        else begin
          mreg[msel] = int'(hist[1][5:0]);
          if (msel == 3) begin
            int d;
            d = mreg[0] * 64 + mreg[1];
            if (d < DEPTH) mtab[d] = mreg[2] * 64 + mreg[3];
          end
        end
      end
      hist.push_front(cfg_port);
      void'(hist.pop_back());
    end
  end

  // per-clock comparison, away from the edge
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      int le;
      chk("R5 rd_data model", int'(rd_data), mreg[msel]);
      le = (int'(lookup_dst) < DEPTH) ? mtab[int'(lookup_dst)] : 0;
      chk("R9 lookup_src model", int'(lookup_src), le);
    end
  end

  task automatic put(input logic [6:0] code, input int lo = 4, input int hi = 4);
    @(negedge clk) cfg_port = {1'b0, code};
    repeat (lo) @(negedge clk);
    cfg_port = {1'b1, code};
    repeat (hi) @(negedge clk);
  endtask

  task automatic route(input int dst, input int src);
    put(7'h40); put(7'(dst >> 6));
    put(7'h41); put(7'(dst & 63));
    put(7'h42); put(7'(src >> 6));
    put(7'h43); put(7'(src & 63));
  endtask

  task automatic look(input string tag, input int dst, input int exp);
    @(negedge clk) lookup_dst = 12'(dst);
    #1 chk(tag, int'(lookup_src), exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 rd_data in reset", int'(rd_data), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rd_data after reset", int'(rd_data), 0);
    look("R1 entry 0 after reset", 0, 0);
    look("R1 entry 15 after reset", 15, 0);

    // R3 / R4 / R5
    put(7'h45); put(7'h2A);
    chk("R4 store into reg 5", int'(rd_data), 'h2A);
    put(7'h11);
    chk("R4 second value keeps choice", int'(rd_data), 'h11);
    put(7'h49); put(7'h3F);
    chk("R5 reg 9 read-back", int'(rd_data), 'h3F);
    put(7'h45);
    chk("R3 choose reg 5 back", int'(rd_data), 'h11);

    // R2: code changes while strobe held high, and a long high hold
    @(negedge clk) cfg_port = 8'h85;
    repeat (8) @(negedge clk);
    chk("R2 code change while high ignored", int'(rd_data), 'h11);
    cfg_port = 8'hC9;
    repeat (8) @(negedge clk);
    chk("R2 select change while high ignored", int'(rd_data), 'h11);

    // R6 with lookup parked on the committed destination
    @(negedge clk) lookup_dst = 12'd7;
    route(7, 66);
    chk("R6 commit dst 7", int'(lookup_src), 66);
    chk("R6 reg 3 keeps value", int'(rd_data), 2);

    // R7
    route(3, 66);
    look("R7 shared source dst 3", 3, 66);
    look("R7 shared source dst 7", 7, 66);
    route(7, 5);
    look("R7 overwrite dst 7", 7, 5);
    look("R7 dst 3 untouched", 3, 66);

    // R8 boundaries
    route(15, 12'hABC);
    look("R8 last entry accepted", 15, 'hABC);
    route(16, 9);
    route(64, 9);
    for (int d = 0; d < DEPTH; d++) look("R8 table after far commits", d, mtab[d]);
    look("R8 entry 0 not aliased", 0, 0);

    // R9 lookup beyond depth
    look("R9 lookup beyond depth", 16, 0);
    look("R9 lookup far", 12'hFFF, 0);

    // R10: stores to other registers and choices leave the table alone
    put(7'h40); put(7'h00); put(7'h41); put(7'h02);
    put(7'h42); put(7'h3F); put(7'h7F); put(7'h15);
    look("R10 dst 2 unchanged", 2, 0);
    look("R10 dst 15 unchanged", 15, 'hABC);

    // tight strobes and random codes, model compared every clock
    for (int n = 0; n < 400; n++) begin
      logic [6:0] c;
      c = 7'($urandom);
      if ((n % 5) == 0) c = 7'h43;
      if ((n % 7) == 0) c = {1'b0, 6'($urandom_range(0, 3))};
      @(negedge clk) lookup_dst = 12'($urandom_range(0, 20));
      put(c, 2, 2);
    end
    repeat (6) @(negedge clk);
    for (int d = 0; d < DEPTH; d++) look("R7 table after random run", d, mtab[d]);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule